// File: doc/BRIEF.md
# Coprocessor Register-Pair Transfer Unit

This block is the register side of a simple coprocessor. It holds sixteen 32-bit registers. It serves single-register reads and writes, and paired transfers that move two words in one operation. A host presents a request: an operation code, a 32-bit instruction word, a phase flag, and up to two write words. One cycle later the block answers done, busy or cannot-handle. A completing read also returns the addressed data.

A programmable wait count can stall completion. While the count is nonzero, a request is answered busy until the programmed number of cycles has passed since the request that started the wait. The host then repeats the request and it completes. A cancel input abandons a pending wait. A one-shot reject flag, armed from a separate input, makes the next paired transfer answer cannot-handle. Paired transfers whose selector field equals one can also be refused, as a build-time option.

Top module: `cop_pair_xfer`

## Requirements
- R1: A single transfer (op 00 read, 01 write) addresses the register given by instruction bits 19:16. A completing write stores `req_wdata0`. A completing read returns that register on `rsp_rdata0`, with `rsp_rdata1` zero.
- R2: A paired transfer (op 10 read, 11 write) addresses the register at instruction bits 3:0 and its successor, with register 15 paired with register 0. A completing paired read returns the first register on `rsp_rdata0` and the successor on `rsp_rdata1`.
- R3: A completing paired write stores `req_wdata0` in the first register and `req_wdata1` in the successor, both in the same cycle.
- R4: With `wait_cycles` = N > 0 and no wait pending, a request is answered busy and starts a wait. Later requests are busy until N cycles after the starting one. A request exactly N cycles later completes, whatever its phase flag, and ends the wait.
- R5: With no wait pending and `wait_cycles` = 0, a request completes only when `req_first` is 1. Otherwise it answers busy and no register changes.
- R6: A pulse on `bounce_set` arms a flag. The next paired transfer answers cannot-handle, clears the flag and changes no register. Single transfers neither use nor clear the flag.
- R7: With parameter `REJECT_SEL1` = 1 and no armed flag, a paired transfer whose instruction bits 7:4 equal 1 answers cannot-handle and changes nothing.
- R8: `rsp_valid` is `req_valid` delayed one cycle. `rsp_code` is 00 done, 01 busy or 10 cannot-handle. Both read-data outputs are zero unless the response is a completing read.
- R9: `req_cancel` ends a pending wait. A request in the same cycle answers busy and changes nothing. The next request starts a fresh wait.
- R10: After reset all registers read zero, no wait is pending, the reject flag is clear and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 00 single read, 01 single write, 10 pair read, 11 pair write |
| req_first | input | 1 | Phase flag, 1 on the first cycle of an operation |
| req_cancel | input | 1 | Abandon a pending wait |
| req_instr | input | 32 | Instruction word carrying the register fields |
| req_wdata0 | input | DW | First write word |
| req_wdata1 | input | DW | Second write word (paired writes) |
| wait_cycles | input | WAITW | Busy-wait length, 0 disables |
| bounce_set | input | 1 | Arm the one-shot reject flag |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | Response code |
| rsp_rdata0 | output | DW | First read word |
| rsp_rdata1 | output | DW | Second read word |

## Verification
A wrong wait counter shows on the very next request as a done or busy code in the wrong cycle. An off-by-one here moves completion exactly one cycle early or late against the programmed count. A corrupted register or a wrong successor index stays hidden until that register is read back, so the random stimulus keeps reading registers it has written, and a final sweep reads all sixteen. A reject flag that is not cleared, or that leaks to single transfers, shows as a wrong cannot-handle code on the following transfer.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
    localparam int NREG = 16;
    localparam int IDXW = $clog2(NREG);
    localparam int IW   = 32;

    typedef enum logic [1:0] {
        RSP_DONE = 2'b00,
        RSP_BUSY = 2'b01,
        RSP_CANT = 2'b10
    } rsp_e;

    typedef enum logic [1:0] {
        OP_RD1 = 2'b00,
        OP_WR1 = 2'b01,
        OP_RD2 = 2'b10,
        OP_WR2 = 2'b11
    } op_e;

    typedef struct packed {
        logic [IDXW-1:0] idx_a;
        logic [IDXW-1:0] idx_b;
        logic            pair;
        logic            wr;
        logic            sel_reject;
    } dec_t;

    // successor index with wraparound at the top of the file
    function automatic logic [IDXW-1:0] succ_idx(input logic [IDXW-1:0] i);
        logic [IDXW-1:0] r;
        if (i == IDXW'(NREG - 1)) r = '0;
        else                      r = i + 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
    import cpx_pkg::*;
#(
    parameter bit REJECT_SEL1 = 1'b1
) (
    input  op_e           op,
    input  logic [IW-1:0] instr,
    output dec_t          d
);
    logic [IDXW-1:0] single_idx;
    logic [IDXW-1:0] pair_idx;
    logic            rej;

    assign single_idx = instr[19:16];
    assign pair_idx   = instr[3:0];

    generate
        if (REJECT_SEL1) begin : g_rej
            assign rej = (instr[7:4] == 4'd1);
        end else begin : g_norej
            assign rej = 1'b0;
        end
    endgenerate

    always_comb begin
        d.pair       = (op == OP_RD2) || (op == OP_WR2);
        d.wr         = (op == OP_WR1) || (op == OP_WR2);
        d.idx_a      = d.pair ? pair_idx : single_idx;
        d.idx_b      = succ_idx(pair_idx);
        d.sel_reject = d.pair && rej;
    end
endmodule

// File: rtl/cpx_regfile.sv
module cpx_regfile
    import cpx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we0,
    input  logic [IDXW-1:0] wi0,
    input  logic [DW-1:0]   wd0,
    input  logic            we1,
    input  logic [IDXW-1:0] wi1,
    input  logic [DW-1:0]   wd1,
    input  logic [IDXW-1:0] ri0,
    input  logic [IDXW-1:0] ri1,
    output logic [DW-1:0]   rd0,
    output logic [DW-1:0]   rd1
);
    logic [DW-1:0] mem [NREG];

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mem[r] <= '0;
                else if (we0 && wi0 == IDXW'(r))
                    mem[r] <= wd0;
                else if (we1 && wi1 == IDXW'(r))
                    mem[r] <= wd1;
            end
        end
    endgenerate

    assign rd0 = mem[ri0];
    assign rd1 = mem[ri1];

    // R3: both words of a paired write land in the same edge
    p_pair_both_r3: assert property (@(posedge clk) disable iff (rst)
        (we0 && we1 && wi0 != wi1) |=>
            (mem[$past(wi0)] == $past(wd0)) && (mem[$past(wi1)] == $past(wd1)))
        else $error("pair write lost a word");
endmodule

// File: rtl/cpx_stall.sv
module cpx_stall #(
    parameter int WAITW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             cancel,
    input  logic [WAITW-1:0] cfg,
    output logic             resolve,
    output logic             bypass
);
    logic             armed;
    logic [WAITW-1:0] cnt;
    logic             load;

    assign load    = req && !armed && (cfg != '0);
    assign resolve = req && armed && (cnt == '0);
    assign bypass  = !armed && (cfg == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (cancel) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            armed <= 1'b1;
            cnt   <= cfg - 1'b1;
        end else if (resolve) begin
            armed <= 1'b0;
        end else if (armed && cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    // R4: a running wait counts down by one each cycle
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && cnt != '0 && !cancel) |=> (armed && cnt == $past(cnt) - 1'b1))
        else $error("wait counter did not step");

    // R4: a resolved wait returns to idle
    p_resolve_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (resolve && !cancel) |=> !armed)
        else $error("wait stayed armed after resolve");

    // R9: cancel leaves the counter idle
    p_cancel_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !armed)
        else $error("cancel did not idle the wait");
endmodule

// File: rtl/cop_pair_xfer.sv
module cop_pair_xfer
    import cpx_pkg::*;
#(
    parameter int DW          = 32,
    parameter int WAITW       = 8,
    parameter bit REJECT_SEL1 = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_first,
    input  logic             req_cancel,
    input  logic [IW-1:0]    req_instr,
    input  logic [DW-1:0]    req_wdata0,
    input  logic [DW-1:0]    req_wdata1,
    input  logic [WAITW-1:0] wait_cycles,
    input  logic             bounce_set,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [DW-1:0]    rsp_rdata0,
    output logic [DW-1:0]    rsp_rdata1
);
    dec_t          d;
    logic          bounce_q;
    logic          live, bounce_hit, sel_hit, stall_req;
    logic          st_resolve, st_bypass, complete;
    logic [DW-1:0] q_a, q_b;
    rsp_e          code_n;

    cpx_decode #(.REJECT_SEL1(REJECT_SEL1)) u_dec (
        .op    (op_e'(req_op)),
        .instr (req_instr),
        .d     (d)
    );

    assign live       = req_valid && !req_cancel;
    assign bounce_hit = live && d.pair && bounce_q;
    assign sel_hit    = live && d.sel_reject && !bounce_q;
    assign stall_req  = live && !bounce_hit && !sel_hit;

    cpx_stall #(.WAITW(WAITW)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .req     (stall_req),
        .cancel  (req_cancel),
        .cfg     (wait_cycles),
        .resolve (st_resolve),
        .bypass  (st_bypass)
    );

    assign complete = stall_req && (st_resolve || (st_bypass && req_first));

    cpx_regfile #(.DW(DW)) u_rf (
        .clk (clk),
        .rst (rst),
        .we0 (complete && d.wr),
        .wi0 (d.idx_a),
        .wd0 (req_wdata0),
        .we1 (complete && d.wr && d.pair),
        .wi1 (d.idx_b),
        .wd1 (req_wdata1),
        .ri0 (d.idx_a),
        .ri1 (d.idx_b),
        .rd0 (q_a),
        .rd1 (q_b)
    );

    always_comb begin
        if (bounce_hit || sel_hit) code_n = RSP_CANT;
        else if (complete)         code_n = RSP_DONE;
        else                       code_n = RSP_BUSY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bounce_q   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_code   <= RSP_DONE;
            rsp_rdata0 <= '0;
            rsp_rdata1 <= '0;
        end else begin
            bounce_q   <= bounce_set || (bounce_q && !bounce_hit);
            rsp_valid  <= req_valid;
            rsp_code   <= code_n;
            rsp_rdata0 <= (complete && !d.wr) ? q_a : '0;
            rsp_rdata1 <= (complete && !d.wr && d.pair) ? q_b : '0;
        end
    end

    // R8: response follows the request by exactly one cycle
    p_rsp_delay_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rsp_valid == $past(req_valid)))
        else $error("response timing wrong");

    // R8: only three legal codes
    p_code_legal_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_code != 2'b11))
        else $error("illegal response code");

    // R6: a consumed reject flag is clear next cycle unless re-armed
    p_bounce_once_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_cancel && req_op[1] && bounce_q && !bounce_set) |=> !bounce_q)
        else $error("reject flag not cleared");

    // R8: a rejected or busy answer never carries read data
    p_no_data_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'b00) |-> (rsp_rdata0 == '0 && rsp_rdata1 == '0))
        else $error("data on non-done response");
endmodule

// File: tb/cop_pair_xfer_test.sv
module cop_pair_xfer_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int WAITW = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid, req_first, req_cancel, bounce_set;
    logic [1:0]       req_op;
    logic [31:0]      req_instr;
    logic [DW-1:0]    req_wdata0, req_wdata1;
    logic [WAITW-1:0] wait_cycles;
    logic             rsp_valid;
    logic [1:0]       rsp_code;
    logic [DW-1:0]    rsp_rdata0, rsp_rdata1;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [31:0] m_reg [16];
    bit          m_bounce;
    bit          m_armed;
    int          m_cnt;

    cop_pair_xfer #(.DW(DW), .WAITW(WAITW), .REJECT_SEL1(1'b1)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_first(req_first), .req_cancel(req_cancel), .req_instr(req_instr),
        .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
        .wait_cycles(wait_cycles), .bounce_set(bounce_set),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_rdata0(rsp_rdata0), .rsp_rdata1(rsp_rdata1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int nxt(input int i);
        return (i == 15) ? 0 : i + 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive, clock, compare against model, update model
    task automatic step(input bit v, input bit cancel, input logic [1:0] op,
                        input logic [31:0] instr, input bit first,
                        input logic [31:0] w0, input logic [31:0] w1,
                        input bit bset, input int cfg, input string tag);
        bit pair, wr, cmpl, cant, load, resolve;
        int a, b;
        logic [1:0]  e_code;
        logic [31:0] e_d0, e_d1;
        req_valid = v; req_cancel = cancel; req_op = op; req_instr = instr;
        req_first = first; req_wdata0 = w0; req_wdata1 = w1;
        bounce_set = bset; wait_cycles = WAITW'(cfg);
        pair = op[1]; wr = op[0];
        a = pair ? int'(instr[3:0]) : int'(instr[19:16]);
        b = nxt(int'(instr[3:0]));
        cant = 0; cmpl = 0; load = 0; resolve = 0;
        e_code = 2'b01; e_d0 = 0; e_d1 = 0;
        if (v && !cancel) begin
            if (pair && m_bounce) cant = 1;
            else if (pair && instr[7:4] == 4'd1) cant = 1;
            if (cant) e_code = 2'b10;
            else if (m_armed) begin
                if (m_cnt == 0) begin resolve = 1; cmpl = 1; end
            end else if (cfg != 0) load = 1;
            else if (first) cmpl = 1;
            if (cmpl) begin
                e_code = 2'b00;
                if (!wr) begin
                    e_d0 = m_reg[a];
                    if (pair) e_d1 = m_reg[b];
                end
            end
        end
        @(posedge clk); #1;
        chk({tag, " valid"}, {31'd0, rsp_valid}, {31'd0, v});
        if (v) begin
            chk({tag, " code"}, {30'd0, rsp_code}, {30'd0, e_code});
            chk({tag, " rdata0"}, rsp_rdata0, e_d0);
            chk({tag, " rdata1"}, rsp_rdata1, e_d1);
        end
        if (cmpl && wr) begin
            m_reg[a] = w0;
            if (pair) m_reg[b] = w1;
        end
        m_bounce = bset || (m_bounce && !(v && !cancel && pair && m_bounce));
        if (cancel) begin m_armed = 0; m_cnt = 0; end
        else if (load) begin m_armed = 1; m_cnt = cfg - 1; end
        else if (resolve) m_armed = 0;
        else if (m_armed && m_cnt != 0) m_cnt--;
        @(negedge clk);
    endtask

    function automatic logic [31:0] si(input int r);
        return 32'(r) << 16;
    endfunction

    function automatic logic [31:0] pi(input int r);
        return 32'(r);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        m_bounce = 0; m_armed = 0; m_cnt = 0;
        rst = 1; req_valid = 0; req_cancel = 0; req_op = 0; req_instr = 0;
        req_first = 0; req_wdata0 = 0; req_wdata1 = 0; bounce_set = 0; wait_cycles = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        chk("R10 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        // R10: every register reads zero after reset
        for (int r = 0; r < 16; r++) step(1, 0, 2'b00, si(r), 1, 0, 0, 0, 0, "R10");

        // R1: single write and read
        step(1, 0, 2'b01, si(5), 1, 32'hA5A5_0005, 0, 0, 0, "R1");
        step(1, 0, 2'b00, si(5), 1, 0, 0, 0, 0, "R1");
        // R2/R3: paired write at top of file wraps to register 0
        step(1, 0, 2'b11, pi(15), 1, 32'h1111_000F, 32'h2222_0000, 0, 0, "R3");
        step(1, 0, 2'b10, pi(15), 1, 0, 0, 0, 0, "R2");
        step(1, 0, 2'b00, si(0), 1, 0, 0, 0, 0, "R2");
        step(1, 0, 2'b11, pi(6), 1, 32'h6666_6666, 32'h7777_7777, 0, 0, "R3");
        step(1, 0, 2'b10, pi(5), 1, 0, 0, 0, 0, "R2");
        // R5: later phase without wait answers busy, no write
        step(1, 0, 2'b01, si(9), 0, 32'hDEAD_BEEF, 0, 0, 0, "R5");
        step(1, 0, 2'b00, si(9), 1, 0, 0, 0, 0, "R5");
        // R6: arm flag, single transfer unaffected, pair bounced, then retry works
        step(0, 0, 2'b00, 0, 0, 0, 0, 1, 0, "R6");
        step(1, 0, 2'b00, si(5), 1, 0, 0, 0, 0, "R6");
        step(1, 0, 2'b11, pi(2), 1, 32'hBAD0_0002, 32'hBAD0_0003, 0, 0, "R6");
        step(1, 0, 2'b10, pi(2), 1, 0, 0, 0, 0, "R6");
        // R7: selector field of 1 refused
        step(1, 0, 2'b11, pi(3) | 32'h10, 1, 32'hBAD1, 32'hBAD2, 0, 0, "R7");
        step(1, 0, 2'b10, pi(3), 1, 0, 0, 0, 0, "R7");
        // R4: wait of 3 cycles, completion on the fourth request
        step(1, 0, 2'b01, si(12), 1, 32'hC0DE_000C, 0, 0, 3, "R4");
        step(1, 0, 2'b01, si(12), 0, 32'hC0DE_000C, 0, 0, 3, "R4");
        step(1, 0, 2'b01, si(12), 0, 32'hC0DE_000C, 0, 0, 3, "R4");
        step(1, 0, 2'b01, si(12), 0, 32'hC0DE_000C, 0, 0, 3, "R4");
        step(1, 0, 2'b00, si(12), 1, 0, 0, 0, 0, "R4");
        // R4: wait of 1 with idle gap
        step(1, 0, 2'b10, pi(11), 1, 0, 0, 0, 1, "R4");
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, 1, "R4");
        step(1, 0, 2'b10, pi(11), 0, 0, 0, 0, 1, "R4");
        // R9: cancel mid-wait, same-cycle request busy, next request restarts
        step(1, 0, 2'b01, si(4), 1, 32'h4444, 0, 0, 2, "R9");
        step(1, 1, 2'b01, si(4), 0, 32'h4444, 0, 0, 2, "R9");
        step(1, 0, 2'b01, si(4), 1, 32'h4444, 0, 0, 2, "R9");
        step(1, 0, 2'b01, si(4), 0, 32'h4444, 0, 0, 2, "R9");
        step(1, 0, 2'b01, si(4), 0, 32'h4444, 0, 0, 2, "R9");
        step(1, 0, 2'b00, si(4), 1, 0, 0, 0, 0, "R9");

        // R8: constrained random mix against the model
        for (int n = 0; n < 4000; n++) begin
            bit v, c, f, bs;
            int cfg;
            logic [31:0] ins;
            v   = ($urandom % 100) < 85;
            c   = ($urandom % 100) < 4;
            f   = ($urandom % 100) < 75;
            bs  = ($urandom % 100) < 4;
            cfg = (($urandom % 100) < 60) ? 0 : int'($urandom % 5);
            ins = $urandom;
            if (($urandom % 10) == 0) ins[7:4] = 4'd1;
            else if (ins[7:4] == 4'd1) ins[7:4] = 4'd0;
            step(v, c, 2'($urandom), ins, f, $urandom, $urandom, bs, cfg, "R8");
        end

        // R1: final sweep of all registers with the wait cleared
        step(0, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R9");
        for (int r = 0; r < 16; r++) step(1, 0, 2'b00, si(r), 1, 0, 0, 0, 0, "R1");

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule